// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an on-chip request bus with valid/ready handshaking and an external asynchronous static RAM. The RAM has 32,768 bytes behind a 15-bit address, a shared 8-bit data bus, and three active-low strobes: select, output enable and write enable. The controller takes one single-byte request at a time. It turns each request into a strobe sequence whose phases are whole clock cycles. The length of each phase is derived from nanosecond timing parameters, rounded up to the next cycle.

A write lowers select and write enable together. Both strobes stay low for a pulse long enough to cover both the minimum write-pulse width and the data setup time. Both strobes rise on the same edge, and the controller keeps driving the data for one further cycle. Output enable stays high for the whole write. A read first spends one cycle with the RAM selected, output enable high and the bus released. It then holds output enable low for the access window and captures the byte on the last cycle of that window. The byte is returned with a one-cycle response pulse. A pacing counter keeps the ready signal low until the configured read or write cycle time has elapsed since the previous access began.

The data bus is presented as separate drive, drive-enable and sense signals; the pad ring merges them into the bidirectional pins.

Top module: `asram_port`

## Requirements
- R1: While reset is asserted and right after it is released, all three strobes (`mem_ce_n`, `mem_oe_n`, `mem_we_n`) are high, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A write holds `mem_ce_n` and `mem_we_n` low together for exactly WP cycles, where WP = max(ceil(T_PWE_NS/CLK_NS), ceil(T_SD_NS/CLK_NS)). Both strobes rise on the same clock edge. Address and write data stay stable for the whole pulse, and `mem_oe_n` stays high.
- R3: `mem_dq_oe` is 1 from the first cycle of the write pulse through the first cycle after the strobes rise, and it is 0 otherwise.
- R4: A read has exactly one setup cycle with `mem_ce_n` low, `mem_oe_n` high and `mem_dq_oe` 0. After it, `mem_oe_n` stays low for exactly RA cycles, where RA = max(ceil(T_DOE_NS/CLK_NS), ceil(T_AA_NS/CLK_NS) - 1).
- R5: The byte on `mem_dq_in` during the last output-enable-low cycle is registered into `rsp_rdata`. `rsp_valid` is high for exactly the one following cycle, which is RA + 2 cycles after the accepting edge.
- R6: After a request is accepted, `req_ready` stays low until the sequence is back idle. It also stays low until at least ceil(T_WC_NS/CLK_NS) cycles for a write, or ceil(T_RC_NS/CLK_NS) cycles for a read, have passed since acceptance. Back-to-back accepts are therefore spaced max(WC, WP + 2) cycles for writes and max(RC, RA + 2) cycles for reads.
- R7: A read returns the byte most recently written to the same address, across the whole 15-bit address range.
- R8: `mem_dq_oe` is never 1 while `mem_oe_n` is low, and `mem_oe_n` is never low while `mem_we_n` is low.
- R9: A request is taken only on an edge where both `req_valid` and `req_ready` are 1. While `req_valid` is 0, changes on the request fields leave all strobes high and `req_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: read byte available |
| rsp_rdata | output | DW | Read byte, held until the next read |
| mem_addr | output | AW | RAM address lines |
| mem_dq_out | output | DW | Byte driven toward the RAM data pins |
| mem_dq_oe | output | 1 | Enables the data-pin drivers |
| mem_dq_in | input | DW | Byte sensed on the RAM data pins |
| mem_ce_n | output | 1 | RAM select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |

## Verification
If the cycle counter in the sequencer holds a wrong value, the fault shows on the strobe pins within the same access: the write pulse or the output-enable window comes out one or more cycles too short or too long. The RAM model also presents the complement of the stored byte until the access window has fully elapsed, so capturing too early returns wrong data on that read's response pulse. A wrong pacing counter shows as accept spacing different from the computed gap on the very next request. A wrong bus-enable state shows as driver and RAM output overlap in the cycle where output enable falls.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WPULSE,
    SQ_WHOLD,
    SQ_RSETUP,
    SQ_RACC
  } sq_state_e;

  // Whole clock cycles covering t_ns, never fewer than one.
  function automatic int ceil_cycles(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Bits needed to hold values 0..n.
  function automatic int count_width(input int n);
    int w;
    w = $clog2(n + 1);
    if (w < 1) w = 1;
    return w;
  endfunction

endpackage

// File: rtl/asram_pace.sv
module asram_pace #(
  parameter int WC_CYC = 1,
  parameter int RC_CYC = 1,
  parameter int CW     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic start_wr_i,
  output logic open_o
);
  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] elapsed_q;
  logic [CW-1:0] need_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      need_q    <= '0;
    end else if (start_i) begin
      elapsed_q <= CW'(1);
      need_q    <= start_wr_i ? CW'(WC_CYC) : CW'(RC_CYC);
    end else if (elapsed_q != SAT) begin
      elapsed_q <= elapsed_q + CW'(1);
    end
  end

  assign open_o = (elapsed_q >= need_q);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int AW     = 15,
  parameter int DW     = 8,
  parameter int WP_CYC = 1,
  parameter int RA_CYC = 1,
  parameter int CW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          start_wr_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [DW-1:0] start_wdata_i,
  output logic          busy_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_out_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_in_i,
  output logic          ce_n_o,
  output logic          oe_n_o,
  output logic          we_n_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          wr_end_o,
  output logic          rd_cap_o
);
  sq_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          last_beat;

  assign last_beat = (cnt_q == '0);
  assign busy_o    = (state_q != SQ_IDLE);
  assign wr_end_o  = (state_q == SQ_WPULSE) && last_beat;
  assign rd_cap_o  = (state_q == SQ_RACC) && last_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= SQ_IDLE;
      cnt_q        <= '0;
      mem_addr_o   <= '0;
      mem_dq_out_o <= '0;
      mem_dq_oe_o  <= 1'b0;
      ce_n_o       <= 1'b1;
      oe_n_o       <= 1'b1;
      we_n_o       <= 1'b1;
      rsp_valid_o  <= 1'b0;
      rsp_rdata_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (start_i) begin
            mem_addr_o <= start_addr_i;
            ce_n_o     <= 1'b0;
            if (start_wr_i) begin
              mem_dq_out_o <= start_wdata_i;
              mem_dq_oe_o  <= 1'b1;
              we_n_o       <= 1'b0;
              cnt_q        <= CW'(WP_CYC - 1);
              state_q      <= SQ_WPULSE;
            end else begin
              state_q <= SQ_RSETUP;
            end
          end
        end
        SQ_WPULSE: begin
          if (last_beat) begin
            we_n_o  <= 1'b1;
            ce_n_o  <= 1'b1;
            state_q <= SQ_WHOLD;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        SQ_WHOLD: begin
          mem_dq_oe_o <= 1'b0;
          state_q     <= SQ_IDLE;
        end
        SQ_RSETUP: begin
          oe_n_o  <= 1'b0;
          cnt_q   <= CW'(RA_CYC - 1);
          state_q <= SQ_RACC;
        end
        SQ_RACC: begin
          if (last_beat) begin
            rsp_rdata_o <= mem_dq_in_i;
            rsp_valid_o <= 1'b1;
            oe_n_o      <= 1'b1;
            ce_n_o      <= 1'b1;
            state_q     <= SQ_IDLE;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/asram_port.sv
module asram_port
  import asram_pkg::*;
#(
  parameter int AW        = 15,
  parameter int DW        = 8,
  parameter int CLK_NS    = 10,
  parameter int T_PWE_NS  = 7,
  parameter int T_SD_NS   = 5,
  parameter int T_AA_NS   = 10,
  parameter int T_DOE_NS  = 5,
  parameter int T_WC_NS   = 10,
  parameter int T_RC_NS   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n
);
  localparam int WP_CYC = max2(ceil_cycles(T_PWE_NS, CLK_NS), ceil_cycles(T_SD_NS, CLK_NS));
  localparam int RA_CYC = max2(ceil_cycles(T_DOE_NS, CLK_NS), ceil_cycles(T_AA_NS, CLK_NS) - 1);
  localparam int WC_CYC = ceil_cycles(T_WC_NS, CLK_NS);
  localparam int RC_CYC = ceil_cycles(T_RC_NS, CLK_NS);
  localparam int CW     = count_width(max2(max2(WP_CYC, RA_CYC), max2(WC_CYC, RC_CYC)) + 1);

  // Named internal events, observed by the bound checker.
  logic acc_start;
  logic seq_busy;
  logic pace_open;
  logic wr_end;
  logic rd_cap;

  assign req_ready = !seq_busy && pace_open;
  assign acc_start = req_valid && req_ready;

  asram_seq #(
    .AW(AW), .DW(DW), .WP_CYC(WP_CYC), .RA_CYC(RA_CYC), .CW(CW)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (acc_start),
    .start_wr_i   (req_write),
    .start_addr_i (req_addr),
    .start_wdata_i(req_wdata),
    .busy_o       (seq_busy),
    .mem_addr_o   (mem_addr),
    .mem_dq_out_o (mem_dq_out),
    .mem_dq_oe_o  (mem_dq_oe),
    .mem_dq_in_i  (mem_dq_in),
    .ce_n_o       (mem_ce_n),
    .oe_n_o       (mem_oe_n),
    .we_n_o       (mem_we_n),
    .rsp_valid_o  (rsp_valid),
    .rsp_rdata_o  (rsp_rdata),
    .wr_end_o     (wr_end),
    .rd_cap_o     (rd_cap)
  );

  asram_pace #(
    .WC_CYC(WC_CYC), .RC_CYC(RC_CYC), .CW(CW)
  ) u_pace (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (acc_start),
    .start_wr_i(req_write),
    .open_o    (pace_open)
  );

endmodule

// File: rtl/asram_port_checker.sv
module asram_port_checker #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          acc_start,
  input logic          wr_end,
  input logic          rd_cap,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n
);

  assert_oe_off_in_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  assert_turnaround_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> (!$past(mem_dq_oe) && !$past(mem_ce_n)));

  assert_write_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  assert_write_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |=> (mem_we_n && mem_ce_n && mem_dq_oe));

  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap |=> rsp_valid);

  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_busy_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> !req_ready);

endmodule

bind asram_port asram_port_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .acc_start (acc_start),
  .wr_end    (wr_end),
  .rd_cap    (rd_cap),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_dq_out(mem_dq_out),
  .mem_dq_oe (mem_dq_oe),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n)
);

// File: tb/asram_port_bench.sv
module asram_port_bench;
  localparam int AW = 15;
  localparam int DW = 8;
  localparam int CLK = 20;

  // Expected cycle counts, worked out by hand-style arithmetic.
  function automatic int cyc(input int ns);
    return ns / CLK + ((ns % CLK) != 0 ? 1 : 0);
  endfunction
  localparam int WP_EXP = (cyc(45) > cyc(30)) ? cyc(45) : cyc(30);         // 3
  localparam int RA_EXP = (cyc(25) > cyc(50) - 1) ? cyc(25) : cyc(50) - 1; // 2
  localparam int WGAP   = (cyc(190) > WP_EXP + 2) ? cyc(190) : WP_EXP + 2; // 10
  localparam int RGAP   = (cyc(10) > RA_EXP + 2) ? cyc(10) : RA_EXP + 2;   // 4

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic          mem_dq_oe;
  logic [DW-1:0] mem_dq_in = '0;
  logic          mem_ce_n, mem_oe_n, mem_we_n;

  always #(CLK / 2) clk = ~clk;

  asram_port #(
    .AW(AW), .DW(DW), .CLK_NS(CLK), .T_PWE_NS(30), .T_SD_NS(45),
    .T_AA_NS(50), .T_DOE_NS(25), .T_WC_NS(190), .T_RC_NS(10)
  ) u_asram_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
  );

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] ram [int];
  logic [7:0] ref_mem [int];
  logic [7:0] exp_q [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ram_val(input int a);
    return ram.exists(a) ? ram[a] : 8'h00;
  endfunction

  // ---------------- RAM model and pin monitor ----------------
  logic          wr_q = 1'b0, rd_q = 1'b0, w_bad = 1'b0;
  int            wlen = 0, rlen = 0;
  logic [AW-1:0] w_addr = '0;
  logic [DW-1:0] w_data = '0;
  logic          p_ce_n = 1'b1, p_oe_n = 1'b1, p_dq_oe = 1'b0;
  int            contention = 0;

  always @(posedge clk) begin
    logic wr_now, rd_now;
    if (rst_n) begin
      wr_now = !mem_ce_n && !mem_we_n;
      rd_now = !mem_ce_n && !mem_oe_n && mem_we_n;
      if (!mem_oe_n && mem_dq_oe) contention++;
      if (wr_now) begin
        if (!wr_q) begin
          wlen   <= 1;
          w_addr <= mem_addr;
          w_data <= mem_dq_out;
          w_bad  <= !mem_oe_n || !mem_dq_oe;
        end else begin
          wlen <= wlen + 1;
          if (mem_addr != w_addr || mem_dq_out != w_data || !mem_oe_n || !mem_dq_oe)
            w_bad <= 1'b1;
        end
      end else if (wr_q) begin
        ram[int'(w_addr)] = w_data;
        check(wlen == WP_EXP, "R2 write pulse cycles", wlen, WP_EXP);
        check(!w_bad, "R2 addr/data/oe stable in pulse", w_bad, 0);
        check(mem_ce_n && mem_we_n && mem_dq_oe, "R3 joint rise with data held",
              {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b111);
      end
      if (rd_now) begin
        if (!rd_q)
          check(!p_ce_n && p_oe_n && !p_dq_oe, "R4 setup cycle before oe",
                {p_ce_n, p_oe_n, p_dq_oe}, 3'b010);
        rlen <= rlen + 1;
      end else begin
        if (rd_q) check(rlen == RA_EXP, "R4 oe low cycles", rlen, RA_EXP);
        rlen <= 0;
      end
      wr_q    <= wr_now;
      rd_q    <= rd_now;
      p_ce_n  <= mem_ce_n;
      p_oe_n  <= mem_oe_n;
      p_dq_oe <= mem_dq_oe;
    end
  end

  // Data pins: complement of the stored byte until the access window is met.
  always @(negedge clk) begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_in <= (rlen >= RA_EXP - 1) ? ram_val(int'(mem_addr)) : ~ram_val(int'(mem_addr));
    else
      mem_dq_in <= 8'h00;
  end

  // Response checker (R5, R7).
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected response", rsp_rdata, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(rsp_rdata == e, "R7 read data", rsp_rdata, e);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic do_write(input int a, input logic [7:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
    while (!req_ready) @(negedge clk);
    ref_mem[a] = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_read(input int a);
    int lat;
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
    while (!req_ready) @(negedge clk);
    exp_q.push_back(ref_mem.exists(a) ? ref_mem[a] : 8'h00);
    lat = 0;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
    check(lat == RA_EXP + 2, "R5 response latency", lat, RA_EXP + 2);
    @(negedge clk);
    check(!rsp_valid, "R5 single-cycle pulse", rsp_valid, 0);
  endtask

  task automatic burst(input int n, input bit wr, input int base);
    int t, last_t, gap;
    t = 0; last_t = -1;
    gap = wr ? WGAP : RGAP;
    for (int i = 0; i < n; i++) begin
      req_valid = 1'b1; req_write = wr; req_addr = AW'(base + i);
      req_wdata = 8'(base + 7 * i);
      while (!req_ready) begin @(negedge clk); t++; end
      if (last_t >= 0) check(t - last_t == gap, "R6 accept spacing", t - last_t, gap);
      if (wr) ref_mem[base + i] = 8'(base + 7 * i);
      else exp_q.push_back(ref_mem.exists(base + i) ? ref_mem[base + i] : 8'h00);
      last_t = t;
      @(negedge clk); t++;
    end
    req_valid = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 150000);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high in reset",
          {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    check(!mem_dq_oe && !rsp_valid, "R1 bus released, no response", {mem_dq_oe, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R1 ready after reset", req_ready, 1);

    // R9: valid low, request fields wiggling
    begin
      int busy_seen;
      busy_seen = 0;
      for (int i = 0; i < 20; i++) begin
        req_write = i[0]; req_addr = AW'(i * 311); req_wdata = 8'(i * 13);
        @(negedge clk);
        if (!mem_ce_n || !mem_we_n || !mem_oe_n || !req_ready) busy_seen++;
      end
      check(busy_seen == 0, "R9 no access without valid", busy_seen, 0);
    end

    // R2/R3/R7: sweep over low addresses, then read back
    for (int a = 0; a < 512; a++) do_write(a, 8'((a * 37 + 5) ^ (a >> 3)));
    for (int a = 0; a < 512; a++) do_read(a);

    // Address range corners, same-address overwrite (R7)
    do_write(32767, 8'hC3); do_write(16384, 8'h3C); do_write(1, 8'hFF);
    do_write(1, 8'h00); do_write(32766, 8'h81);
    do_read(32767); do_read(16384); do_read(1); do_read(32766);

    // Random pairs across the full range (R7)
    for (int i = 0; i < 300; i++) begin
      int a;
      a = int'($urandom_range(32767));
      do_write(a, 8'($urandom));
      do_read(int'($urandom_range(32767)) & 32'h7FFF);
      do_read(a);
    end

    // R6: back-to-back spacing, writes then reads
    burst(6, 1'b1, 20000);
    burst(6, 1'b0, 20000);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R5 every read answered", exp_q.size(), 0);
    check(contention == 0, "R8 no drive while oe low", contention, 0);
    finish_up();
  end

endmodule